// File: doc/BRIEF.md
# HDLC FIFO Status and Event Register

This block sits between a byte-wide HDLC framer and a host register bus. It holds a transmit FIFO, which the host fills and the framer drains, and a receive FIFO, which the framer fills and the host drains. Each FIFO is 128 bytes deep. A single 8-bit status word combines two kinds of bit. Four bits are live conditions worked out from the FIFO fill counts and two host-programmed watermark registers. Three bits are sticky packet events that the framer sets with one-cycle pulses and that a host read of the status word clears.

The host port is a plain register interface. `host_addr` selects one of four registers:

| Address | Register |
|---|---|
| 0 | Status word |
| 1 | Transmit low watermark |
| 2 | Receive high watermark |
| 3 | FIFO data |

`host_rdata` is combinational from `host_addr`. Any side effect of a read (a clear or a pop) takes place at the clock edge where `host_rd` is high.

The framer takes transmit bytes over a valid/ready stream. A byte moves on every edge where both `tx_valid` and `tx_ready` are high. `tx_ready` may stay low for any length of time, and `tx_data` then holds steady. Received bytes arrive through a plain push strobe. The receiver cannot back-pressure the framer. A push into a full FIFO is lost, and `rx_overrun` reports the loss in the same cycle.

Top module: `hdlc_fifo_status`

## Requirements
- R1: While `rst_n` is low, `host_rdata` at address 0 reads 0x00. After reset, both watermark registers read 0 and both FIFOs are empty.
- R2: Status bit 0 is 1 exactly when the transmit FIFO holds fewer than 128 bytes.
- R3: Status bit 1 is 1 exactly when the transmit fill count is strictly less than the transmit low-watermark register (address 1).
- R4: Status bit 2 is 1 exactly when the receive FIFO holds at least one byte.
- R5: Status bit 3 is 1 exactly when the receive fill count is strictly greater than the receive high-watermark register (address 2).
- R6: Status bit 4 is set by an `ev_rx_start` pulse. It stays set until a host read of address 0 clears it. Reads of other addresses leave it alone.
- R7: Status bit 5 is set by an `ev_rx_end` pulse, and also by a receive push that is dropped. It is cleared by a host read of address 0.
- R8: Status bit 6 is set by an `ev_tx_end` pulse and is cleared by a host read of address 0.
- R9: If an event pulse arrives in the same cycle as a clearing read, its bit is 1 after that edge. Status bit 7 always reads 0.
- R10: A host write to address 3 appends a byte to the transmit FIFO when it is not full. When it is full, the write is dropped.
- R11: `tx_valid` is high while the transmit FIFO is not empty. Bytes leave in the order they were written, one per edge where `tx_valid` and `tx_ready` are both high.
- R12: A `rx_push` while the receive FIFO is full is dropped, and `rx_overrun` is 1 in that same cycle.
- R13: A host read of address 3 returns the oldest receive byte and removes it. When the FIFO is empty, the read returns 0x00 and has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| host_addr | input | 2 | Register select: 0 status, 1 transmit low watermark, 2 receive high watermark, 3 FIFO data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe; the side effect of a read happens at this edge |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from `host_addr` |
| tx_data | output | 8 | Oldest byte in the transmit FIFO |
| tx_valid | output | 1 | Transmit FIFO is not empty |
| tx_ready | input | 1 | Framer takes `tx_data` at this edge |
| rx_push | input | 1 | Framer delivers `rx_data` |
| rx_data | input | 8 | Received byte |
| rx_overrun | output | 1 | The current push is being dropped because the receive FIFO is full |
| ev_rx_start | input | 1 | Pulse: opening flag detected |
| ev_rx_end | input | 1 | Pulse: received packet ended (good CRC, CRC error, overrun or abort) |
| ev_tx_end | input | 1 | Pulse: message transmission finished |

## Verification
A wrong fill count appears in the live status bits in the cycle right after the faulty edge. It also appears in `tx_valid`, and later in the order or number of bytes that drain out. A sticky bit that is cleared wrongly, or that misses a set, shows on the very next read of the status word. The most sensitive cases are the edge where a pulse meets a clearing read, and the pushes made at the full boundary, where a dropped byte would otherwise show up as an extra byte during the drain.

// File: rtl/hfs_pkg.sv
`timescale 1ns/1ps
package hfs_pkg;
  typedef enum logic [1:0] {
    REG_STATUS = 2'd0,
    REG_TXLWM  = 2'd1,
    REG_RXHWM  = 2'd2,
    REG_DATA   = 2'd3
  } reg_sel_e;

  localparam int NUM_EVENTS = 3;
  localparam int EV_RXSTART = 0;
  localparam int EV_RXEND   = 1;
  localparam int EV_TXEND   = 2;
endpackage

// File: rtl/hfs_byte_fifo.sv
`timescale 1ns/1ps
module hfs_byte_fifo #(
  parameter int W     = 8,
  parameter int DEPTH = 128,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  wdata,
  input  logic          pop,
  output logic [W-1:0]  rdata,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic          push_ok, pop_ok;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr];

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (push_ok) mem[wptr] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      count <= '0;
    end else begin
      if (push_ok) wptr <= bump(wptr);
      if (pop_ok)  rptr <= bump(rptr);
      unique case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  // R10 / R12: occupancy never exceeds the depth
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  // R10 / R12: a push into a full FIFO with no pop leaves the count unchanged
  a_r12_full_push_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (push && full && !pop) |=> (count == $past(count)));

  // R13: a pop of an empty FIFO with no push leaves it empty
  a_r13_empty_pop_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && empty && !push) |=> empty);
endmodule

// File: rtl/hfs_event_bank.sv
`timescale 1ns/1ps
module hfs_event_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic         clr,
  output logic [N-1:0] q
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      q[i] <= 1'b0;
      else if (set[i]) q[i] <= 1'b1;
      else if (clr)    q[i] <= 1'b0;
    end
  end

  // R9: a pulse is never lost, even against a clearing read
  a_r9_set_survives_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (|set) |=> ((q & $past(set)) == $past(set)));

  // R6: a clear with no pulse empties the bank
  a_r6_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && (set == '0)) |=> (q == '0));

  // R6: without a clear, no bit falls
  a_r6_bits_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((q & $past(q)) == $past(q)));
endmodule

// File: rtl/hdlc_fifo_status.sv
`timescale 1ns/1ps
module hdlc_fifo_status
  import hfs_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int W     = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   host_addr,
  input  logic         host_wr,
  input  logic         host_rd,
  input  logic [W-1:0] host_wdata,
  output logic [W-1:0] host_rdata,
  output logic [W-1:0] tx_data,
  output logic         tx_valid,
  input  logic         tx_ready,
  input  logic         rx_push,
  input  logic [W-1:0] rx_data,
  output logic         rx_overrun,
  input  logic         ev_rx_start,
  input  logic         ev_rx_end,
  input  logic         ev_tx_end
);
  localparam int CW = $clog2(DEPTH + 1);

  reg_sel_e              sel;
  logic [CW-1:0]         tx_cnt, rx_cnt;
  logic                  tx_full, tx_empty, rx_full, rx_empty;
  logic [W-1:0]          rx_head;
  logic [W-1:0]          tx_lwm, rx_hwm;
  logic [NUM_EVENTS-1:0] ev_set, ev_q;
  logic                  tx_wr, rx_rd, stat_rd;
  logic [7:0]            status;

  assign sel     = reg_sel_e'(host_addr);
  assign tx_wr   = host_wr && (sel == REG_DATA);
  assign rx_rd   = host_rd && (sel == REG_DATA);
  assign stat_rd = host_rd && (sel == REG_STATUS);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_lwm <= '0;
      rx_hwm <= '0;
    end else if (host_wr) begin
      if (sel == REG_TXLWM) tx_lwm <= host_wdata;
      if (sel == REG_RXHWM) rx_hwm <= host_wdata;
    end
  end

  hfs_byte_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_txq (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr), .wdata(host_wdata),
    .pop(tx_ready), .rdata(tx_data),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty)
  );

  hfs_byte_fifo #(.W(W), .DEPTH(DEPTH), .CW(CW)) u_rxq (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .wdata(rx_data),
    .pop(rx_rd), .rdata(rx_head),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty)
  );

  assign tx_valid   = !tx_empty;
  assign rx_overrun = rx_push && rx_full;

  always_comb begin
    ev_set             = '0;
    ev_set[EV_RXSTART] = ev_rx_start;
    ev_set[EV_RXEND]   = ev_rx_end || rx_overrun;
    ev_set[EV_TXEND]   = ev_tx_end;
  end

  hfs_event_bank #(.N(NUM_EVENTS)) u_events (
    .clk(clk), .rst_n(rst_n), .set(ev_set), .clr(stat_rd), .q(ev_q)
  );

  always_comb begin
    status    = '0;
    status[0] = !tx_full;
    status[1] = {{(W + 1 - CW){1'b0}}, tx_cnt} < {1'b0, tx_lwm};
    status[2] = !rx_empty;
    status[3] = {{(W + 1 - CW){1'b0}}, rx_cnt} > {1'b0, rx_hwm};
    status[4] = ev_q[EV_RXSTART];
    status[5] = ev_q[EV_RXEND];
    status[6] = ev_q[EV_TXEND];
    if (!rst_n) status = '0;
  end

  always_comb begin
    unique case (sel)
      REG_STATUS: host_rdata = status;
      REG_TXLWM:  host_rdata = tx_lwm;
      REG_RXHWM:  host_rdata = rx_hwm;
      default:    host_rdata = rx_empty ? '0 : rx_head;
    endcase
  end

  // R7: a dropped receive push leaves the packet-end bit set
  a_r7_overrun_sets_end: assert property (@(posedge clk) disable iff (!rst_n)
    rx_overrun |=> ev_q[EV_RXEND]);

  // R11: a byte offered and not taken stays put
  a_r11_tx_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !tx_wr) |=> (tx_valid && $stable(tx_data)));

  // R9: the unused top bit of the status word is always low
  a_r9_top_bit_low: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == REG_STATUS) |-> !host_rdata[7]);
endmodule

// File: tb/tb_hdlc_fifo_status.sv
`timescale 1ns/1ps
module tb_hdlc_fifo_status;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;
  localparam int NSTEP      = 12;

  // entry: kind[20:18] addr[17:16] data[15:8] expected_status[7:0]
  // kind 0 host write, 1 receive push, 2 transmit take, 3 event pulses
  // (data bit0 rx start, bit1 rx end, bit2 tx end), 4 status read
  localparam logic [20:0] STEPS [NSTEP] = '{
    {3'd0, 2'd1, 8'h02, 8'h03},  // R3 low watermark 2, tx empty
    {3'd0, 2'd2, 8'h01, 8'h03},  // R5 high watermark 1
    {3'd0, 2'd3, 8'hA1, 8'h03},  // R10 tx count 1 < 2
    {3'd0, 2'd3, 8'hA2, 8'h01},  // R3 tx count 2 not < 2
    {3'd1, 2'd0, 8'h55, 8'h05},  // R4 rx holds one
    {3'd1, 2'd0, 8'h66, 8'h0D},  // R5 rx 2 > 1
    {3'd2, 2'd0, 8'h00, 8'h0F},  // R11 tx drained to 1
    {3'd3, 2'd0, 8'h01, 8'h1F},  // R6 start event
    {3'd3, 2'd0, 8'h04, 8'h5F},  // R8 tx end event
    {3'd4, 2'd0, 8'h00, 8'h0F},  // R6 R8 cleared by read
    {3'd3, 2'd0, 8'h02, 8'h2F},  // R7 end event
    {3'd4, 2'd0, 8'h00, 8'h0F}   // R7 cleared
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] host_addr = '0;
  logic       host_wr = 1'b0, host_rd = 1'b0;
  logic [7:0] host_wdata = '0;
  logic [7:0] host_rdata;
  logic [7:0] tx_data;
  logic       tx_valid;
  logic       tx_ready = 1'b0;
  logic       rx_push = 1'b0;
  logic [7:0] rx_data = '0;
  logic       rx_overrun;
  logic       ev_rx_start = 1'b0, ev_rx_end = 1'b0, ev_tx_end = 1'b0;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hdlc_fifo_status dut (
    .clk(clk), .rst_n(rst_n),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_push(rx_push), .rx_data(rx_data), .rx_overrun(rx_overrun),
    .ev_rx_start(ev_rx_start), .ev_rx_end(ev_rx_end), .ev_tx_end(ev_tx_end)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    host_wr = 0; host_rd = 0; host_addr = 2'd0; tx_ready = 0; rx_push = 0;
    ev_rx_start = 0; ev_rx_end = 0; ev_tx_end = 0;
  endtask

  // one-cycle operation: drive at a falling edge, release at the next
  task automatic host_write(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1;
    @(negedge clk); idle(); #1;
  endtask

  task automatic host_read(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); host_addr = a; host_rd = 1; #1; d = host_rdata;
    @(negedge clk); idle(); #1;
  endtask

  task automatic push_rx(input logic [7:0] d);
    @(negedge clk); rx_data = d; rx_push = 1;
    @(negedge clk); idle(); #1;
  endtask

  task automatic pulse_events(input logic [2:0] e);
    @(negedge clk); ev_rx_start = e[0]; ev_rx_end = e[1]; ev_tx_end = e[2];
    @(negedge clk); idle(); #1;
  endtask

  task automatic apply_reset();
    @(negedge clk); rst_n = 0; idle(); #1;
    check(host_rdata == 8'h00, "R1 status during reset", host_rdata, 8'h00);
    @(negedge clk); rst_n = 1; #1;
  endtask

  initial begin : watchdog
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired actual=0x%0h expected=0x%0h", 0, 1);
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] rd;
    int errs;
    idle();
    repeat (2) @(negedge clk);
    #1;
    check(host_rdata == 8'h00, "R1 status held in reset", host_rdata, 8'h00);
    rst_n = 1; #1;
    check(host_rdata == 8'h01, "R1 R2 status after reset", host_rdata, 8'h01);
    check(tx_valid == 1'b0, "R1 R11 tx empty after reset", tx_valid, 0);

    // table walk
    for (int i = 0; i < NSTEP; i++) begin
      logic [2:0] kind;
      logic [1:0] a;
      logic [7:0] d, ex;
      {kind, a, d, ex} = STEPS[i];
      case (kind)
        3'd0: host_write(a, d);
        3'd1: push_rx(d);
        3'd2: begin
          @(negedge clk); tx_ready = 1;
          @(negedge clk); idle(); #1;
        end
        3'd3: pulse_events(d[2:0]);
        default: host_read(2'd0, rd);
      endcase
      check(host_rdata == ex, $sformatf("R2/R3/R4/R5/R6/R7/R8 table step %0d", i),
            host_rdata, ex);
    end

    // reset clears everything, including a pending event
    pulse_events(3'b001);
    apply_reset();
    check(host_rdata == 8'h01, "R1 status after second reset", host_rdata, 8'h01);
    host_read(2'd1, rd);
    check(rd == 8'h00, "R1 low watermark reset", rd, 8'h00);
    host_read(2'd2, rd);
    check(rd == 8'h00, "R1 high watermark reset", rd, 8'h00);

    // transmit fill past full
    for (int i = 0; i < 130; i++) host_write(2'd3, 8'(i));
    check(host_rdata[0] == 1'b0, "R2 full tx clears not-full bit", host_rdata[0], 0);
    errs = 0;
    for (int i = 0; i < 128; i++) begin
      @(negedge clk); #1;
      if (!(tx_valid && tx_data == 8'(i))) errs++;
      tx_ready = 1;
      @(negedge clk); idle(); #1;
    end
    check(errs == 0, "R10 R11 tx drain order", errs, 0);
    check(tx_valid == 1'b0, "R10 overflow writes dropped", tx_valid, 0);
    check(host_rdata[0] == 1'b1, "R2 not-full after drain", host_rdata[0], 1);

    // receive fill and overrun
    for (int i = 0; i < 128; i++) push_rx(8'(i + 16));
    check(host_rdata == 8'h0D, "R4 R5 rx full status", host_rdata, 8'h0D);
    @(negedge clk); rx_data = 8'hEE; rx_push = 1; #1;
    check(rx_overrun == 1'b1, "R12 overrun flag on full push", rx_overrun, 1);
    @(negedge clk); idle(); #1;
    check(host_rdata == 8'h2D, "R7 overrun latches packet end", host_rdata, 8'h2D);
    errs = 0;
    for (int i = 0; i < 128; i++) begin
      host_read(2'd3, rd);
      if (rd != 8'(i + 16)) errs++;
    end
    check(errs == 0, "R12 R13 rx read order, dropped byte absent", errs, 0);
    host_read(2'd3, rd);
    check(rd == 8'h00, "R13 empty read returns zero", rd, 8'h00);
    check(host_rdata == 8'h21, "R4 R13 rx empty after drain", host_rdata, 8'h21);

    // pulse meets clearing read
    @(negedge clk); host_addr = 2'd0; host_rd = 1; ev_tx_end = 1;
    @(negedge clk); idle(); #1;
    check(host_rdata == 8'h41, "R9 event kept against clear", host_rdata, 8'h41);
    check(host_rdata[7] == 1'b0, "R9 top bit reads zero", host_rdata[7], 0);

    // non-status read leaves events
    pulse_events(3'b001);
    host_read(2'd1, rd);
    check(host_rdata[4] == 1'b1, "R6 other reads do not clear", host_rdata[4], 1);
    host_read(2'd0, rd);
    check(rd == 8'h51, "R6 R8 read returns pre-clear value", rd, 8'h51);
    check(host_rdata == 8'h01, "R6 R8 status read clears", host_rdata, 8'h01);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule